// File: doc/BRIEF.md
# Serial Audio Receiver With Format Detection

This block turns a stereo serial audio stream into parallel left and right sample words. It runs on the bit clock itself. On every rising edge it samples the serial data line and the frame clock. It watches the frame clock for transitions, and those transitions place each word.

Two framings are accepted, and the block tells them apart without any mode register. In the first framing, a long frame-clock phase carries one channel: high for left and low for right. The last bit before each transition is the LSB of a 24-bit word. In the second framing, the frame clock is only a short sync pulse. A 16-bit left word follows the pulse, then a 16-bit right word. The block selects this framing when the high pulse spans a small number of bit clocks. A static pin chooses whether the first data bit coincides with the last sync bit or comes one bit later.

Each completed frame raises a one-cycle valid strobe. A flag reports which framing the frame used.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `left_word`, `right_word`, `frame_valid` and `dsp_mode` are all zero.
- R2: In the long-phase framing, the bit sampled on the last rising edge with `lrclk` high is the LSB of `left_word`. The bit sampled on the last rising edge with `lrclk` low is the LSB of `right_word`. Each word is 24 bits, MSB first.
- R3: A long phase may hold more than 24 bits. The extra bits at the start of the phase are discarded, and only the final 24 affect the word.
- R4: `frame_valid` is high for exactly one cycle per completed frame. In the long-phase framing, it is high on the cycle after the edge that first samples `lrclk` high following a right phase.
- R5: A high pulse sampled on 4 or fewer rising edges selects the sync-pulse framing. A high pulse sampled on 5 or more edges does not.
- R6: With `dsp_late` = 1, the MSB of the left word is sampled on the first rising edge at which `lrclk` is low after the sync pulse.
- R7: With `dsp_late` = 0, the MSB of the left word is sampled on the last rising edge at which `lrclk` is high.
- R8: In the sync-pulse framing, 16 left bits are followed by 16 right bits, each word MSB first. Each word appears in bits [23:8] of its output, with bits [7:0] zero. `frame_valid` is high on the cycle after the edge that follows the 32nd data bit. Bits after that edge are ignored.
- R9: `dsp_mode` is 1 after a sync-pulse frame and 0 after a long-phase frame. It changes only on the cycle in which `frame_valid` is high.
- R10: After reset, no frame is reported until a low-to-high `lrclk` transition has been seen. A frame clock that is already high when reset is released does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Frame clock: channel select, or sync pulse |
| sdata | input | 1 | Serial audio data |
| dsp_late | input | 1 | Static select of the sync-pulse sub-format: 1 late, 0 early |
| left_word | output | 24 | Last captured left sample |
| right_word | output | 24 | Last captured right sample |
| frame_valid | output | 1 | One-cycle strobe after a complete frame |
| dsp_mode | output | 1 | Framing of the last reported frame: 1 sync-pulse, 0 long-phase |

## Verification
The assertions take for granted that `lrclk` and `sdata` change only between rising bit-clock edges. They also assume that each frame obeys its framing. A long phase must last at least 24 bits. A sync-pulse frame must run at least 32 data bits before the next pulse. The stimulus meets both assumptions by driving every input on the falling edge, and by building each frame from whole words with idle gaps. The one deliberate breach is a five-bit pulse, which the bench uses to check that the pulse is not taken as a sync.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int RJ_BITS  = 24,
  parameter int DSP_BITS = 16,
  parameter int SYNC_MAX = 4
) (
  input  logic               bclk,
  input  logic               rst_n,
  input  logic               lrclk,
  input  logic               sdata,
  input  logic               dsp_late,
  output logic [RJ_BITS-1:0] left_word,
  output logic [RJ_BITS-1:0] right_word,
  output logic               frame_valid,
  output logic               dsp_mode
);

  localparam int FRAME_BITS = 2 * DSP_BITS;
  localparam int NW         = $clog2(FRAME_BITS + 2);
  localparam int HW         = $clog2(SYNC_MAX + 2);
  localparam int PADW       = RJ_BITS - DSP_BITS;

  logic               lr_q;
  logic [RJ_BITS-1:0] shreg;
  logic [HW-1:0]      hi_cnt;
  logic [NW-1:0]      nbits;
  logic               synced;
  logic               have_left;

  logic               rise, fall, short_pulse, counting;
  logic [RJ_BITS-1:0] dsp_word;

  assign rise        = lrclk & ~lr_q;
  assign fall        = ~lrclk & lr_q;
  assign short_pulse = hi_cnt <= HW'(SYNC_MAX);
  assign counting    = (nbits != '0) && (nbits <= NW'(FRAME_BITS));
  assign dsp_word    = {shreg[DSP_BITS-1:0], {PADW{1'b0}}};

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q        <= 1'b1;
      shreg       <= '0;
      hi_cnt      <= '0;
      nbits       <= '0;
      synced      <= 1'b0;
      have_left   <= 1'b0;
      left_word   <= '0;
      right_word  <= '0;
      frame_valid <= 1'b0;
      dsp_mode    <= 1'b0;
    end else begin
      lr_q        <= lrclk;
      shreg       <= {shreg[RJ_BITS-2:0], sdata};
      frame_valid <= 1'b0;

      if (rise)
        hi_cnt <= HW'(1);
      else if (lrclk && hi_cnt != HW'(SYNC_MAX + 1))
        hi_cnt <= hi_cnt + HW'(1);

      if (rise) begin
        synced    <= 1'b1;
        nbits     <= '0;
        have_left <= 1'b0;
        if (have_left) begin
          right_word  <= shreg;
          frame_valid <= 1'b1;
          dsp_mode    <= 1'b0;
        end
      end else if (fall && synced) begin
        have_left <= ~short_pulse;
        if (short_pulse)
          nbits <= dsp_late ? NW'(1) : NW'(2);
        else begin
          nbits     <= '0;
          left_word <= shreg;
        end
      end else if (counting) begin
        nbits <= nbits + NW'(1);
        if (nbits == NW'(DSP_BITS))
          left_word <= dsp_word;
        if (nbits == NW'(FRAME_BITS)) begin
          right_word  <= dsp_word;
          frame_valid <= 1'b1;
          dsp_mode    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int RJ_BITS  = 24,
  parameter int DSP_BITS = 16
) (
  input logic               bclk,
  input logic               rst_n,
  input logic               lrclk,
  input logic [RJ_BITS-1:0] right_word,
  input logic               frame_valid,
  input logic               dsp_mode
);

  localparam int PADW = RJ_BITS - DSP_BITS;

  // R4
  valid_single_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R4
  rj_valid_after_rise_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_valid && !dsp_mode) |-> ($past(lrclk) && !$past(lrclk, 2)));

  // R9
  mode_moves_with_valid_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(dsp_mode) |-> frame_valid);

  // R8
  dsp_low_bits_zero_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_valid && dsp_mode) |-> (right_word[PADW-1:0] == '0));

  // R4
  right_moves_with_valid_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(right_word) |-> frame_valid);

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.RJ_BITS(RJ_BITS), .DSP_BITS(DSP_BITS)) chk_i (
  .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .right_word(right_word),
  .frame_valid(frame_valid), .dsp_mode(dsp_mode)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b1;
  logic        sdata = 1'b0;
  logic        dsp_late = 1'b1;
  logic [23:0] left_word, right_word;
  logic        frame_valid, dsp_mode;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  serial_audio_rx uut (
    .bclk(clk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata), .dsp_late(dsp_late),
    .left_word(left_word), .right_word(right_word),
    .frame_valid(frame_valid), .dsp_mode(dsp_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lr, input logic d);
    @(negedge clk);
    lrclk = lr;
    sdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 left", {8'h0, left_word}, 0);
    chk("R1 right", {8'h0, right_word}, 0);
    chk("R1 valid", {31'h0, frame_valid}, 0);
    chk("R1 mode", {31'h0, dsp_mode}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", {31'h0, frame_valid}, 0);
    chk("R1 mode after release", {31'h0, dsp_mode}, 0);
    repeat (29) drive(1'b1, 1'b1);
    repeat (30) drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);
    @(negedge clk);
    chk("R10 no frame before first rise", {31'h0, frame_valid}, 0);
  endtask

  task automatic t_rj(input logic [23:0] l, input logic [23:0] r,
                      input int padl, input int padr);
    idle(4);
    for (int i = 0; i < padl; i++) drive(1'b1, 1'b1);
    for (int i = 23; i >= 0; i--) drive(1'b1, l[i]);
    for (int i = 0; i < padr; i++) drive(1'b0, i[0]);
    for (int i = 23; i >= 0; i--) drive(1'b0, r[i]);
    drive(1'b1, 1'b0);
    @(negedge clk);
    chk("R4 rj valid", {31'h0, frame_valid}, 1);
    chk(padl > 0 ? "R3 left" : "R2 left", {8'h0, left_word}, {8'h0, l});
    chk(padr > 0 ? "R3 right" : "R2 right", {8'h0, right_word}, {8'h0, r});
    chk("R9 rj mode", {31'h0, dsp_mode}, 0);
    @(negedge clk);
    chk("R4 valid one cycle", {31'h0, frame_valid}, 0);
  endtask

  task automatic t_dsp(input logic late, input int width, input logic [15:0] l,
                       input logic [15:0] r, input logic expect_dsp,
                       input logic prev_mode);
    logic [31:0] bits;
    bits = {l, r};
    dsp_late = late;
    idle(4);
    if (late) begin
      for (int i = 0; i < width; i++) drive(1'b1, 1'b0);
      for (int i = 31; i >= 0; i--) begin
        drive(1'b0, bits[i]);
        if (i == 8) chk("R9 mode held mid-frame", {31'h0, dsp_mode}, {31'h0, prev_mode});
      end
    end else begin
      for (int i = 0; i < width - 1; i++) drive(1'b1, 1'b0);
      drive(1'b1, bits[31]);
      for (int i = 30; i >= 0; i--) begin
        drive(1'b0, bits[i]);
        if (i == 8) chk("R9 mode held mid-frame", {31'h0, dsp_mode}, {31'h0, prev_mode});
      end
    end
    drive(1'b0, 1'b1);
    @(negedge clk);
    if (expect_dsp) begin
      chk("R8 dsp valid", {31'h0, frame_valid}, 1);
      chk(late ? "R6 left late" : "R7 left early", {8'h0, left_word}, {8'h0, l, 8'h00});
      chk("R8 right", {8'h0, right_word}, {8'h0, r, 8'h00});
      chk("R9 dsp mode", {31'h0, dsp_mode}, 1);
      drive(1'b0, 1'b1);
      chk("R4 dsp valid one cycle", {31'h0, frame_valid}, 0);
      chk("R8 trailing bits ignored", {8'h0, right_word}, {8'h0, r, 8'h00});
    end else begin
      chk("R5 wide pulse not sync", {31'h0, frame_valid}, 0);
      chk("R9 mode unchanged", {31'h0, dsp_mode}, {31'h0, prev_mode});
    end
  endtask

  initial begin
    t_reset();
    t_rj(24'hA5A5A5, 24'h3C3C3C, 0, 0);
    t_rj(24'h800001, 24'h7FFFFE, 8, 3);
    t_dsp(1'b1, 1, 16'h1234, 16'hABCD, 1'b1, 1'b0);
    t_dsp(1'b0, 1, 16'h8001, 16'h7FFE, 1'b1, 1'b1);
    t_dsp(1'b1, 4, 16'hFFFF, 16'h0001, 1'b1, 1'b1);
    t_dsp(1'b0, 4, 16'h5A5A, 16'hC3C3, 1'b1, 1'b1);
    t_dsp(1'b1, 5, 16'h1111, 16'h2222, 1'b0, 1'b1);
    t_rj(24'h0F0F0F, 24'hF0F0F0, 2, 0);
    t_dsp(1'b1, 2, 16'h6789, 16'h9876, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule